// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block watches three conditions that should force a system into reset: a supply that has dropped below its safe level, a push-button style manual reset, and a processor that has stopped servicing its watchdog. It drives a single reset line. The supply condition arrives as a ready-made digital flag from an analog comparator outside the block, which is assumed already synchronous to the clock. The manual reset and the watchdog service input come from asynchronous sources and are synchronized inside.

Every time reset is asserted, the block holds it for a selectable release delay after the cause has gone away. A watchdog timeout produces a reset pulse of exactly one release delay, and the watchdog then starts over. Both the timeout and the release delay are counted in ticks of a slow timebase strobe (nominally 3.125 ms), chosen from small tables by two select inputs. A parameter sets the reset output as active-low or active-high.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low and in the cycles straight after it, the reset output is in the asserted state. After `rst_n` rises with no fault present, it releases on the tick that completes one release delay.
- R2: When `supply_ok` is sampled low at a clock edge, the reset output is asserted from that edge on.
- R3: After the last fault clears, the output stays asserted until exactly N timebase ticks have been counted, where N follows `dly_sel`: 0→512, 1→128, 2→64, 3→32, 4→16, 5→8, 6 and 7→1. Release happens only on a tick.
- R4: `mr_n` passes through a two-flop synchronizer. Driving it low asserts the reset output on the third clock edge after the change. The output stays asserted while it is held low, and for one full release delay after it returns high.
- R5: Both a rising and a falling edge on `wd_in` (after its two-flop synchronizer) restart the watchdog count, so toggling faster than the timeout never asserts reset.
- R6: If no watchdog edge arrives within M ticks while released, the output is asserted on the M-th tick. M follows `wd_sel`: 0→512, 1→128, 2→64, 3→32, 4→16, 5 to 7→2. The output is then held for one release delay, released, and the watchdog restarts from zero.
- R7: While the output is asserted, the watchdog count is held at zero, so after any release a timeout needs a full M ticks.
- R8: A new fault (supply low or manual reset low) during the release delay restarts the delay from zero.
- R9: With `ACTIVE_LOW` = 1 the output is low when asserted and high when released. With `ACTIVE_LOW` = 0 the levels are swapped.
- R10: When a watchdog edge and the tick that would complete the timeout fall in the same cycle, the edge wins and reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous initialization |
| tick | input | 1 | One-cycle timebase strobe |
| supply_ok | input | 1 | High when supply is above the release level |
| mr_n | input | 1 | Asynchronous manual reset, active low |
| wd_in | input | 1 | Asynchronous watchdog service input, any edge is a kick |
| wd_sel | input | 3 | Watchdog timeout select |
| dly_sel | input | 3 | Release delay select |
| rst_out | output | 1 | Reset output, polarity set by `ACTIVE_LOW` |

## Verification
Two collisions matter most. The first is a synchronized watchdog edge landing in the same cycle as the tick that would end the timeout. The second is a fault arriving while the release delay is running. A random phase uses the shortest watchdog timeout with frequent toggles and single-cycle supply and manual-reset pulses, so both coincidences happen many times. Every cycle is judged against a bench reference model of the requirements, and directed runs measure exact tick counts for each delay and timeout.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned MAX_SHIFT = 9;            // longest setting: 2**9 ticks
    localparam int unsigned CNT_W     = MAX_SHIFT + 1;
    localparam int unsigned WD_STEPS  = 5;            // selects below this scale by powers of two
    localparam int unsigned REL_STEPS = 6;
    localparam int unsigned WD_MIN_SHIFT  = 1;        // shortest timeout: 2 ticks
    localparam int unsigned REL_MIN_SHIFT = 0;        // shortest delay: 1 tick

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] tcnt_t;

    typedef enum logic {
        ST_RELEASED = 1'b0,
        ST_ASSERTED = 1'b1
    } hold_state_e;

    // Setting 0 is the long one; each step after it divides by a further power of two.
    function automatic tcnt_t scaled_limit(input sel_t sel, input int unsigned steps,
                                           input int unsigned min_shift);
        tcnt_t one;
        one = tcnt_t'(1);
        if (sel == '0) begin
            return one << MAX_SHIFT;
        end else if (int'(sel) < int'(steps)) begin
            return one << (MAX_SHIFT - 1 - int'(sel));
        end
        return one << min_shift;
    endfunction

    function automatic tcnt_t wd_limit(input sel_t sel);
        return scaled_limit(sel, WD_STEPS, WD_MIN_SHIFT);
    endfunction

    function automatic tcnt_t rel_limit(input sel_t sel);
        return scaled_limit(sel, REL_STEPS, REL_MIN_SHIFT);
    endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int unsigned     WIDTH   = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(STAGES); i++) begin
            if (!rst_n) begin
                stage_q[i] <= RST_VAL;
            end else begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
    import rsv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  wd_s,
    input  logic  hold,
    input  tcnt_t limit,
    output logic  kick,
    output logic  expire,
    output tcnt_t cnt
);

    typedef struct packed {
        tcnt_t cnt;
        logic  prev;
    } wd_reg_t;

    wd_reg_t        r_d, r_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        r_d      = r_q;
        r_d.prev = wd_s;
        kick     = wd_s ^ r_q.prev;
        cnt_inc  = {1'b0, r_q.cnt} + 1'b1;
        // A kick in the same cycle as the final tick cancels the timeout.
        expire   = !hold && !kick && tick && (cnt_inc >= {1'b0, limit});
        if (hold || kick || expire) begin
            r_d.cnt = '0;
        end else if (tick) begin
            r_d.cnt = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt = r_q.cnt;

endmodule

// File: rtl/rsv_hold.sv
module rsv_hold
    import rsv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  fault,
    input  logic  expire,
    input  tcnt_t limit,
    output logic  det,
    output tcnt_t cnt
);

    typedef struct packed {
        hold_state_e st;
        tcnt_t       cnt;
    } hold_reg_t;

    hold_reg_t      r_d, r_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        r_d     = r_q;
        cnt_inc = {1'b0, r_q.cnt} + 1'b1;
        unique case (r_q.st)
            ST_ASSERTED: begin
                if (fault) begin
                    r_d.cnt = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, limit}) begin
                        r_d.st  = ST_RELEASED;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            default: begin
                if (fault || expire) begin
                    r_d.st  = ST_ASSERTED;
                    r_d.cnt = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_ASSERTED;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign det = (r_q.st == ST_ASSERTED);
    assign cnt = r_q.cnt;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter bit          ACTIVE_LOW  = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             supply_ok,
    input  logic             mr_n,
    input  logic             wd_in,
    input  logic [SEL_W-1:0] wd_sel,
    input  logic [SEL_W-1:0] dly_sel,
    output logic             rst_out
);

    localparam int unsigned N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_s;
    logic               mr_s;
    logic               wd_s;
    logic               fault;
    logic               kick;
    logic               expire;
    logic               det_q;
    tcnt_t              wd_lim;
    tcnt_t              rel_lim;
    tcnt_t              wd_cnt;
    tcnt_t              hold_cnt;

    rsv_sync #(
        .WIDTH   (N_ASYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mr_n, wd_in}),
        .q     (async_s)
    );

    assign mr_s = async_s[1];
    assign wd_s = async_s[0];

    always_comb begin
        wd_lim  = wd_limit(wd_sel);
        rel_lim = rel_limit(dly_sel);
        fault   = !supply_ok || !mr_s;
    end

    rsv_wdog u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wd_s   (wd_s),
        .hold   (det_q),
        .limit  (wd_lim),
        .kick   (kick),
        .expire (expire),
        .cnt    (wd_cnt)
    );

    rsv_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .fault  (fault),
        .expire (expire),
        .limit  (rel_lim),
        .det    (det_q),
        .cnt    (hold_cnt)
    );

    generate
        if (ACTIVE_LOW) begin : g_pol_low
            assign rst_out = ~det_q;
        end else begin : g_pol_high
            assign rst_out = det_q;
        end
    endgenerate

endmodule

// File: rtl/rsv_supervisor_chk.sv
module rsv_supervisor_chk
    import rsv_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  tick,
    input logic  supply_ok,
    input logic  fault,
    input logic  mr_s,
    input logic  kick,
    input logic  expire,
    input tcnt_t wd_cnt,
    input tcnt_t hold_cnt,
    input logic  det_q
);

    AST_INIT_ASSERTED: assert property (@(posedge clk) $rose(rst_n) |-> det_q); // R1

    AST_SUPPLY_LOW_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> det_q); // R2

    AST_RELEASE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q && !tick) |=> det_q); // R3

    AST_MANUAL_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_s |=> det_q); // R4

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (wd_cnt == '0)); // R5

    AST_TIMEOUT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> det_q); // R6

    AST_WD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        det_q |=> (wd_cnt == '0)); // R7

    AST_FAULT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q && fault) |=> (det_q && hold_cnt == '0)); // R8

    AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !det_q && !fault) |=> !det_q); // R10

endmodule

bind rst_supervisor rsv_supervisor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .supply_ok (supply_ok),
    .fault     (fault),
    .mr_s      (mr_s),
    .kick      (kick),
    .expire    (expire),
    .wd_cnt    (wd_cnt),
    .hold_cnt  (hold_cnt),
    .det_q     (det_q)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;

    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       supply_ok = 1'b1;
    logic       mr_n = 1'b1;
    logic       wd_in = 1'b0;
    logic [2:0] wd_sel = 3'd0;
    logic [2:0] dly_sel = 3'd4;
    logic       rst_lo, rst_hi;

    always #4 clk = ~clk;

    rst_supervisor #(.ACTIVE_LOW(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .mr_n(mr_n),
        .wd_in(wd_in), .wd_sel(wd_sel), .dly_sel(dly_sel), .rst_out(rst_lo));

    rst_supervisor #(.ACTIVE_LOW(1'b0)) u_dut_ah (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .mr_n(mr_n),
        .wd_in(wd_in), .wd_sel(wd_sel), .dly_sel(dly_sel), .rst_out(rst_hi));

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;

    task automatic check_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic int exp_wd(input logic [2:0] s);
        case (s)
            3'd0: return 512;
            3'd1: return 128;
            3'd2: return 64;
            3'd3: return 32;
            3'd4: return 16;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_rel(input logic [2:0] s);
        case (s)
            3'd0: return 512;
            3'd1: return 128;
            3'd2: return 64;
            3'd3: return 32;
            3'd4: return 16;
            3'd5: return 8;
            default: return 1;
        endcase
    endfunction

    // Timebase strobe: one cycle in TDIV.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == 0);
    end

    // Reference model of the requirements.
    bit ms1, ms2, ws1, ws2, wp, m_det;
    int m_wc, m_hc;
    bit flt, kk, ex;
    always @(posedge clk) begin
        if (!rst_n) begin
            ms1 <= 1'b1; ms2 <= 1'b1; ws1 <= 1'b0; ws2 <= 1'b0; wp <= 1'b0;
            m_det <= 1'b1; m_wc <= 0; m_hc <= 0;
        end else begin
            flt = !supply_ok || !ms2;
            kk  = (ws2 != wp);
            ex  = !m_det && !kk && tick && (m_wc + 1 >= exp_wd(wd_sel));
            ms1 <= mr_n; ms2 <= ms1; ws1 <= wd_in; ws2 <= ws1; wp <= ws2;
            if (m_det || kk || ex) m_wc <= 0;
            else if (tick) m_wc <= m_wc + 1;
            if (m_det) begin
                if (flt) m_hc <= 0;
                else if (tick) begin
                    if (m_hc + 1 >= exp_rel(dly_sel)) begin
                        m_det <= 1'b0; m_hc <= 0;
                    end else m_hc <= m_hc + 1;
                end
            end else if (flt || ex) begin
                m_det <= 1'b1; m_hc <= 0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check_eq(cur_req, int'(rst_lo), int'(!m_det));
            check_eq("R9", int'(rst_hi), int'(m_det));
        end
    end

    // Tick counters for directed measurements.
    bit md1 = 1'b1, md2 = 1'b1;
    int rel_ticks = 0;   // ticks since the last fault cleared
    int w_ticks = 0;     // ticks while released
    int d_ticks = 0;     // ticks while asserted
    always @(posedge clk) begin
        md1 <= mr_n; md2 <= md1;
        if (!rst_n || !(supply_ok && md2)) rel_ticks <= 0;
        else if (tick) rel_ticks <= rel_ticks + 1;
        if (rst_lo == 1'b0) w_ticks <= 0;
        else if (tick) w_ticks <= w_ticks + 1;
        if (rst_lo == 1'b1) d_ticks <= 0;
        else if (tick) d_ticks <= d_ticks + 1;
    end

    task automatic wait_out(input logic lvl, input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (rst_lo == lvl) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic pulse_supply(input int cyc);
        supply_ok = 1'b0;
        repeat (cyc) @(negedge clk);
        supply_ok = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        bit ok;
        int lo_cycles;
        int seed_v;
        seed_v = $urandom(32'h5eed_0042);

        // R1: reset state and first release
        repeat (3) @(negedge clk);
        check_eq("R1", int'(rst_lo), 0);
        check_eq("R9", int'(rst_hi), 1);
        cmp_en = 1'b1;
        rst_n = 1'b1;
        wait_out(1'b1, 16 * TDIV + 20, ok);
        check_eq("R1", int'(ok), 1);
        check_eq("R1", rel_ticks, 16);

        // R2: supply drop asserts after one edge
        cur_req = "R2";
        supply_ok = 1'b0;
        @(negedge clk);
        check_eq("R2", int'(rst_lo), 0);
        repeat (9) @(negedge clk);

        // R3: release delay lengths
        cur_req = "R3";
        dly_sel = 3'd2;
        supply_ok = 1'b1;
        wait_out(1'b1, 64 * TDIV + 20, ok);
        check_eq("R3", rel_ticks, 64);
        dly_sel = 3'd5;
        pulse_supply(1);
        wait_out(1'b1, 8 * TDIV + 20, ok);
        check_eq("R3", rel_ticks, 8);

        // R4: manual reset through the synchronizer
        cur_req = "R4";
        repeat (5) @(negedge clk);
        mr_n = 1'b0;
        @(negedge clk);
        check_eq("R4", int'(rst_lo), 1);
        @(negedge clk);
        check_eq("R4", int'(rst_lo), 1);
        @(negedge clk);
        check_eq("R4", int'(rst_lo), 0);
        repeat (40) @(negedge clk);
        check_eq("R4", int'(rst_lo), 0);
        mr_n = 1'b1;
        wait_out(1'b1, 8 * TDIV + 20, ok);
        check_eq("R4", rel_ticks, 8);

        // R8: faults during the release delay restart it
        cur_req = "R8";
        dly_sel = 3'd2;
        pulse_supply(2);
        repeat (30 * TDIV) @(negedge clk);
        check_eq("R8", int'(rst_lo), 0);
        pulse_supply(1);
        wait_out(1'b1, 64 * TDIV + 20, ok);
        check_eq("R8", rel_ticks, 64);
        pulse_supply(1);
        repeat (20 * TDIV) @(negedge clk);
        mr_n = 1'b0;
        repeat (6) @(negedge clk);
        mr_n = 1'b1;
        wait_out(1'b1, 70 * TDIV + 20, ok);
        check_eq("R8", rel_ticks, 64);

        // R6: watchdog timeout, pulse length and restart
        cur_req = "R6";
        wd_sel = 3'd5;
        dly_sel = 3'd5;
        pulse_supply(2);
        wait_out(1'b1, 8 * TDIV + 20, ok);
        wait_out(1'b0, 2 * TDIV + 20, ok);
        check_eq("R6", w_ticks, 2);
        wait_out(1'b1, 8 * TDIV + 20, ok);
        check_eq("R6", d_ticks, 8);
        wait_out(1'b0, 2 * TDIV + 20, ok);
        check_eq("R6", w_ticks, 2);

        // R7: watchdog count cleared while asserted
        cur_req = "R7";
        wd_sel = 3'd4;
        dly_sel = 3'd6;
        wait_out(1'b1, 8 * TDIV + 20, ok);
        repeat (10 * TDIV) @(negedge clk);
        pulse_supply(3);
        wait_out(1'b1, TDIV + 20, ok);
        wait_out(1'b0, 16 * TDIV + 20, ok);
        check_eq("R7", int'(ok), 1);
        check_eq("R7", w_ticks, 16);

        // R5: both edges service the watchdog
        cur_req = "R5";
        wait_out(1'b1, TDIV + 20, ok);
        lo_cycles = 0;
        for (int k = 0; k < 20; k++) begin
            wd_in = ~wd_in;
            for (int c = 0; c < 10 * TDIV; c++) begin
                @(negedge clk);
                if (rst_lo == 1'b0) lo_cycles++;
            end
        end
        check_eq("R5", lo_cycles, 0);
        wait_out(1'b0, 16 * TDIV + 20, ok);
        check_eq("R5", int'(ok), 1);

        // R10: random mix, kicks colliding with the final timeout tick
        cur_req = "R10";
        for (int n = 0; n < 8000; n++) begin
            @(negedge clk);
            if (n % 1000 == 0) begin
                wd_sel = 3'(3 + $urandom % 5);
                dly_sel = 3'(3 + $urandom % 5);
            end
            supply_ok = (($urandom % 300) != 0);
            mr_n = (($urandom % 400) != 0);
            if (($urandom % 6) == 0) wd_in = ~wd_in;
        end
        supply_ok = 1'b1;
        mr_n = 1'b1;
        repeat (4) @(negedge clk);
        cmp_en = 1'b0;
        finish_run();
    end

endmodule